// File: doc/BRIEF.md
# VLIW Packet Slot Assigner

This block sits between instruction fetch and issue in a very-long-instruction-word pipeline. It takes one 32-bit instruction word per cycle and groups consecutive words into packets of one to four words. A marker bit in each word shows where a packet ends. Each word in a packet gets one of four execution slots, numbered 3 down to 0. The word at the lowest address takes the highest slot it may legally use. Each later word must take a slot strictly below the one before it, so some slots may stay empty.

The class of each word comes from a 3-bit field. A fixed table lists, for each class, the slots that class may run in. Slots are chosen greedily: each word takes the highest legal slot below the previous word's slot. If no such slot exists, the packet is reported as an exception. A packet that runs to four words without an end marker is also reported as an exception.

Words enter through a valid/ready handshake. A word is accepted on any clock edge where `in_valid` and `in_ready` are both high. Finished packets leave through a second valid/ready handshake, one packet per cycle. When the output register is full and the consumer holds `out_ready` low, the block lowers `in_ready`. The packet on the output then stays unchanged until the consumer takes it.

Top module: `vliw_slot_assigner`

## Requirements
- R1: The class field is word bits [31:29]. Bit 28 is the end-of-packet marker. A word with bit 28 set is the last word of its packet.
- R2: Slot legality per class, as a 4-bit mask where bit i means slot i is allowed:
  - class 0: 1111
  - class 1: 0011
  - class 2: 1100
  - class 3: 0001
  - class 4: 1000
  - class 5: 0101
  - class 6: 1010
  - class 7: 0000

  The first word of a packet takes the highest slot set in its class mask.
- R3: Each later word takes the highest slot that is legal for its class and strictly below the previous word's slot. For a packet without an exception:
  - `out_slot_vld` bit i is 1 exactly when some word took slot i.
  - `out_slot_word[32*i+31:32*i]` holds that word.
  - An empty slot has its valid bit at 0 and its word field at zero.
- R4: A four-word packet of class-0 words places its words, in arrival order, in slots 3, 2, 1, 0. `out_slot_vld` is 1111.
- R5: If a word has no legal slot left, the packet is emitted with `out_exc`=1, `out_slot_vld`=0000 and all word fields zero. The remaining words of that packet are still consumed, up to its end.
- R6: A fourth word without the end marker closes the packet as an exception: `out_exc`=1 and `out_slot_vld`=0000. The next word starts a new packet.
- R7: `out_valid` rises on the clock edge that accepts a packet's last word. While `out_valid` is high and `out_ready` is low, all output fields hold their values.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: A synchronous reset clears `out_valid` and discards any partly assembled packet. After reset, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Packet available |
| out_ready | input | 1 | Consumer takes the packet |
| out_slot_vld | output | 4 | Per-slot occupied flags, bit i = slot i |
| out_slot_word | output | 128 | Per-slot words, slot i in bits [32i+31:32i] |
| out_exc | output | 1 | Packet raised an exception |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- Packets with gaps, such as a class-2 word followed by a class-1 word. A design that assigned slots by position instead of by class would fill adjacent slots here.
- A class-3 word followed by a second word. No slot is left below slot 0, so a design that let slots repeat or rise would emit a legal-looking packet instead of an exception.
- Unmarked four-word runs. These catch a design that keeps collecting past four words or swallows the word after an overflow.
- Reset in the middle of a packet. This catches a design that leaks the stale words into the next packet.
- Random back-pressure on `out_ready`. This exposes a design that changes or drops a packet it is holding.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int unsigned VSA_WORD_W  = 32;
  localparam int unsigned VSA_NSLOT   = 4;
  localparam int unsigned VSA_CLASS_W = 3;
  // class c legality mask in bits [4c+3:4c], bit i = slot i
  localparam logic [31:0] VSA_MASKS   = 32'h0A58_1C3F;
endpackage

// File: rtl/vsa_slot_pick.sv
module vsa_slot_pick #(
  parameter int unsigned NSLOT   = vsa_pkg::VSA_NSLOT,
  parameter int unsigned CLASS_W = vsa_pkg::VSA_CLASS_W,
  parameter logic [(1<<CLASS_W)*NSLOT-1:0] MASKS = vsa_pkg::VSA_MASKS,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic [CLASS_W-1:0] cls,
  input  logic [NSLOT-1:0]   avail,
  output logic [SLOT_W-1:0]  slot,
  output logic               ok
);
  logic [NSLOT-1:0] cand;

  always_comb begin
    cand = MASKS[int'(cls)*NSLOT +: NSLOT] & avail;
    ok   = |cand;
    slot = '0;
    for (int i = 0; i < NSLOT; i++)
      if (cand[i]) slot = SLOT_W'(i);
  end
endmodule

// File: rtl/vsa_pkt_collect.sv
module vsa_pkt_collect #(
  parameter int unsigned WORD_W  = vsa_pkg::VSA_WORD_W,
  parameter int unsigned NSLOT   = vsa_pkg::VSA_NSLOT,
  parameter int unsigned CLASS_W = vsa_pkg::VSA_CLASS_W,
  parameter logic [(1<<CLASS_W)*NSLOT-1:0] MASKS = vsa_pkg::VSA_MASKS,
  localparam int unsigned SLOT_W = $clog2(NSLOT),
  localparam int unsigned CNT_W  = $clog2(NSLOT),
  localparam int unsigned EOP_B  = WORD_W - 1 - CLASS_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_en,
  input  logic [WORD_W-1:0]       word,
  output logic                    emit,
  output logic [NSLOT-1:0]        e_vld,
  output logic [NSLOT*WORD_W-1:0] e_words,
  output logic                    e_exc
);
  logic [NSLOT-1:0]        acc_vld;
  logic [NSLOT*WORD_W-1:0] acc_words;
  logic [NSLOT-1:0]        avail;
  logic [CNT_W-1:0]        cnt;
  logic                    err;

  logic [CLASS_W-1:0]      cls;
  logic                    eop, ok, last, over, bad, place;
  logic [SLOT_W-1:0]       slot;
  logic [NSLOT-1:0]        nxt_vld, below;
  logic [NSLOT*WORD_W-1:0] nxt_words;

  assign cls   = word[WORD_W-1 -: CLASS_W];
  assign eop   = word[EOP_B];
  assign last  = eop || (cnt == CNT_W'(NSLOT-1));
  assign over  = !eop && (cnt == CNT_W'(NSLOT-1));
  assign place = ok && !err;
  assign bad   = err || !ok || over;

  vsa_slot_pick #(.NSLOT(NSLOT), .CLASS_W(CLASS_W), .MASKS(MASKS)) u_pick (
    .cls(cls), .avail(avail), .slot(slot), .ok(ok)
  );

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign nxt_vld[i] = acc_vld[i] || (place && slot == SLOT_W'(i));
      assign nxt_words[i*WORD_W +: WORD_W] =
        (place && slot == SLOT_W'(i)) ? word : acc_words[i*WORD_W +: WORD_W];
      assign below[i] = (i < int'(slot));
    end
  endgenerate

  assign emit    = acc_en && last;
  assign e_exc   = bad;
  assign e_vld   = bad ? '0 : nxt_vld;
  assign e_words = bad ? '0 : nxt_words;

  always_ff @(posedge clk) begin
    if (rst || (acc_en && last)) begin
      acc_vld   <= '0;
      acc_words <= '0;
      avail     <= '1;
      cnt       <= '0;
      err       <= 1'b0;
    end else if (acc_en) begin
      acc_vld   <= nxt_vld;
      acc_words <= nxt_words;
      cnt       <= cnt + 1'b1;
      err       <= err || !ok;
      if (ok) avail <= below;
    end
  end

  // R3
  taken_above_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld & avail) == '0);
  // R3
  one_slot_per_word_chk: assert property (@(posedge clk) disable iff (rst)
    !err |-> ($countones(acc_vld) == int'(cnt)));
endmodule

// File: rtl/vsa_pkt_outreg.sv
module vsa_pkt_outreg #(
  parameter int unsigned WORD_W = vsa_pkg::VSA_WORD_W,
  parameter int unsigned NSLOT  = vsa_pkg::VSA_NSLOT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [NSLOT-1:0]        l_vld,
  input  logic [NSLOT*WORD_W-1:0] l_words,
  input  logic                    l_exc,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [NSLOT-1:0]        out_slot_vld,
  output logic [NSLOT*WORD_W-1:0] out_slot_word,
  output logic                    out_exc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_slot_vld  <= '0;
      out_slot_word <= '0;
      out_exc       <= 1'b0;
    end else if (load) begin
      out_valid     <= 1'b1;
      out_slot_vld  <= l_vld;
      out_slot_word <= l_words;
      out_exc       <= l_exc;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_slot_vld)
      && $stable(out_slot_word) && $stable(out_exc));
  // R5
  exc_empty_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_exc |-> out_slot_vld == '0);
  // R3
  good_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_exc |-> out_slot_vld != '0);
endmodule

// File: rtl/vliw_slot_assigner.sv
module vliw_slot_assigner #(
  parameter int unsigned WORD_W  = vsa_pkg::VSA_WORD_W,
  parameter int unsigned NSLOT   = vsa_pkg::VSA_NSLOT,
  parameter int unsigned CLASS_W = vsa_pkg::VSA_CLASS_W,
  parameter logic [(1<<CLASS_W)*NSLOT-1:0] MASKS = vsa_pkg::VSA_MASKS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_word,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NSLOT-1:0]        out_slot_vld,
  output logic [NSLOT*WORD_W-1:0] out_slot_word,
  output logic                    out_exc
);
  logic                    acc_en, emit, e_exc;
  logic [NSLOT-1:0]        e_vld;
  logic [NSLOT*WORD_W-1:0] e_words;

  assign in_ready = !out_valid || out_ready;
  assign acc_en   = in_valid && in_ready;

  vsa_pkt_collect #(.WORD_W(WORD_W), .NSLOT(NSLOT), .CLASS_W(CLASS_W), .MASKS(MASKS)) u_collect (
    .clk(clk), .rst(rst), .acc_en(acc_en), .word(in_word),
    .emit(emit), .e_vld(e_vld), .e_words(e_words), .e_exc(e_exc)
  );

  vsa_pkt_outreg #(.WORD_W(WORD_W), .NSLOT(NSLOT)) u_out (
    .clk(clk), .rst(rst), .load(emit), .l_vld(e_vld), .l_words(e_words), .l_exc(e_exc),
    .out_ready(out_ready), .out_valid(out_valid), .out_slot_vld(out_slot_vld),
    .out_slot_word(out_slot_word), .out_exc(out_exc)
  );

  // R7
  emit_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    emit |=> out_valid);
endmodule

// File: tb/vliw_slot_assigner_test.sv
`timescale 1ns/1ps
module vliw_slot_assigner_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [3:0]   out_slot_vld;
  logic [127:0] out_slot_word;
  logic         out_exc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vliw_slot_assigner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
    .out_slot_word(out_slot_word), .out_exc(out_exc)
  );

  function automatic logic [3:0] cls_mask(input logic [2:0] c);
    case (c)
      3'd0: return 4'b1111;
      3'd1: return 4'b0011;
      3'd2: return 4'b1100;
      3'd3: return 4'b0001;
      3'd4: return 4'b1000;
      3'd5: return 4'b0101;
      3'd6: return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [2:0] c, input logic e, input logic [27:0] p);
    return {c, e, p};
  endfunction

  // reference model state
  logic [3:0]   m_avail;
  logic [3:0]   m_vld;
  logic [127:0] m_words;
  int           m_cnt;
  bit           m_err;
  logic [132:0] exp_q[$];
  string        tag_q[$];

  task automatic mdl_clear();
    m_avail = 4'b1111; m_vld = '0; m_words = '0; m_cnt = 0; m_err = 0;
  endtask

  task automatic mdl_accept(input logic [31:0] w);
    logic [3:0] cand;
    int s;
    bit eop, over;
    cand = cls_mask(w[31:29]) & m_avail;
    eop = w[28];
    s = -1;
    for (int i = 0; i < 4; i++) if (cand[i]) s = i;
    if (s < 0) m_err = 1;
    else begin
      if (!m_err) begin m_vld[s] = 1'b1; m_words[s*32 +: 32] = w; end
      m_avail = 4'((1 << s) - 1);
    end
    over = !eop && m_cnt == 3;
    if (eop || m_cnt == 3) begin
      if (m_err || over) exp_q.push_back({1'b1, 4'b0000, 128'd0});
      else exp_q.push_back({1'b0, m_vld, m_words});
      tag_q.push_back(over ? "R6" : m_err ? "R5" : (m_vld == 4'hF ? "R4" : "R3"));
      mdl_clear();
    end else m_cnt++;
  endtask

  task automatic chk(input bit cond, input string req, input logic [132:0] act, input logic [132:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor at negedge, away from the active edge
  bit           hold_pend = 0;
  logic [132:0] held;
  always @(negedge clk) begin
    if (rst) begin
      mdl_clear(); exp_q.delete(); tag_q.delete(); hold_pend = 0;
    end else if (!done) begin
      // R8
      chk(in_ready == (!out_valid || out_ready), "R8", 133'(in_ready), 133'(!out_valid || out_ready));
      // R7
      if (hold_pend)
        chk(out_valid && {out_exc, out_slot_vld, out_slot_word} == held, "R7",
            {out_exc, out_slot_vld, out_slot_word}, held);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R3", {out_exc, out_slot_vld, out_slot_word}, '0);
        else begin
          logic [132:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk({out_exc, out_slot_vld, out_slot_word} == e, t, {out_exc, out_slot_vld, out_slot_word}, e);
        end
      end
      hold_pend = out_valid && !out_ready;
      held = {out_exc, out_slot_vld, out_slot_word};
      if (in_valid && in_ready) mdl_accept(in_word);
    end
  end

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_word = w;
    forever begin
      @(negedge clk);
      if (in_ready) begin @(posedge clk); #1; break; end
    end
    in_valid = 1'b0;
  endtask

  // final word of a packet with out_ready high: result visible one edge later
  task automatic send_last(input logic [31:0] w, input logic [4:0] exp, input string req);
    send(w);
    @(negedge clk);
    chk(out_valid && {out_exc, out_slot_vld} == exp, req, 133'({out_exc, out_slot_vld}), 133'(exp));
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && in_ready, "R9", 133'({out_valid, in_ready}), 133'(2'b01));
    @(posedge clk); #1;
    out_ready = 1'b1;
    // R1: single marked word ends packet, class 0 -> slot 3
    send_last(mk(3'd0, 1'b1, 28'h1), 5'b0_1000, "R1");
    // R2: class 1 alone -> slot 1
    send_last(mk(3'd1, 1'b1, 28'h2), 5'b0_0010, "R2");
    // R4: full packet 3,2,1,0
    send(mk(3'd0, 1'b0, 28'h11)); send(mk(3'd0, 1'b0, 28'h12)); send(mk(3'd0, 1'b0, 28'h13));
    send_last(mk(3'd0, 1'b1, 28'h14), 5'b0_1111, "R4");
    // R3: class 2 then class 1 -> slots 3 and 1, gaps
    send(mk(3'd2, 1'b0, 28'h21));
    send_last(mk(3'd1, 1'b1, 28'h22), 5'b0_1010, "R3");
    // R3: class 5 then class 5 -> slots 2 and 0
    send(mk(3'd5, 1'b0, 28'h23));
    send_last(mk(3'd5, 1'b1, 28'h24), 5'b0_0101, "R3");
    // R5: class 3 at slot 0 then anything -> exception
    send(mk(3'd3, 1'b0, 28'h31));
    send_last(mk(3'd0, 1'b1, 28'h32), 5'b1_0000, "R5");
    // R5: class 7 never legal
    send_last(mk(3'd7, 1'b1, 28'h33), 5'b1_0000, "R5");
    // R6: four unmarked words, then a fresh one-word packet
    send(mk(3'd0, 1'b0, 28'h41)); send(mk(3'd0, 1'b0, 28'h42)); send(mk(3'd0, 1'b0, 28'h43));
    send_last(mk(3'd0, 1'b0, 28'h44), 5'b1_0000, "R6");
    send_last(mk(3'd4, 1'b1, 28'h45), 5'b0_1000, "R6");
    // R9: reset in mid-packet discards the partial words
    send(mk(3'd0, 1'b0, 28'h51)); send(mk(3'd0, 1'b0, 28'h52));
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
    send_last(mk(3'd1, 1'b1, 28'h53), 5'b0_0010, "R9");
    // random traffic with random back-pressure
    fork
      begin
        for (int n = 0; n < 3000; n++) begin
          logic [31:0] w;
          w = $urandom;
          w[31:29] = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 3);
          w[28] = ($urandom % 3 == 0);
          if ($urandom % 4 == 0) begin @(posedge clk); #1; end
          send(w);
        end
      end
      begin
        while (!done) begin
          out_ready = ($urandom % 3 != 0);
          @(posedge clk); #1;
          if (total > 0 && in_valid == 1'b0 && exp_q.size() == 0 && $urandom % 1000 == 999) ;
        end
      end
      begin
        #(4 * 12000);
      end
    join_any
    // drain
    out_ready = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R3", 133'(exp_q.size()), 133'(0));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule